// File: doc/BRIEF.md
# I2C Port Expander Transaction Master

This block is a two-wire bus master that runs one complete single-byte transfer to an 8-bit quasi-bidirectional port expander for each request. A request names one of eight devices, chooses write or read, and for a write carries an output pattern and a mask of pins that serve as inputs. The master builds the address byte from the fixed group code `0100`, the three-bit device number and the direction bit. It then drives start, address, acknowledge, data and stop onto open-drain SCL and SDA lines. It reports whether any acknowledge was missing, and for a read it returns the byte sampled from the expander.

Both bus lines are modelled as active-high "pull low" enables plus the sampled level of SDA. Each bit period is split into four quarters. One quarter lasts `quarter_div + 1` clock cycles, and the divisor is captured when a request is accepted. Every transfer has the same length: a start slot, eighteen bit slots and a stop slot, which is 80 quarters in all.

Top module: `i2c_expander_master`

## Requirements
- R1: The address byte on the bus is, MSB first, the group code `0100`, then `req_dev[2:0]`, then the direction bit, which is 1 for a read and 0 for a write.
- R2: A write places on the bus a start, the address byte, an acknowledge slot, the data byte, a second acknowledge slot and a stop, with exactly one start and one stop per request.
- R3: The data byte of a write equals `req_pattern | req_inmask`, so that every pin marked as an input in the mask is written as 1.
- R4: A read places on the bus a start, the address byte, an acknowledge slot and eight data slots. The master shifts each sampled SDA value in at the LSB, so the first bit received ends up as `rd_data[7]`. It then releases SDA for one slot as a not-acknowledge and sends a stop.
- R5: SDA changes while SCL is released only twice per transfer: it falls during the start and rises during the stop. All other changes of SDA happen while SCL is held low.
- R6: `ack_err` is cleared when a request is accepted. It is set if either acknowledge slot samples SDA high. The stop condition is still sent in that case.
- R7: `busy` rises the cycle after an accepted `req_start` and stays high until the transfer ends. `done` is high for exactly one cycle, in the first cycle with `busy` low. `rd_data` is valid at that point.
- R8: A `req_start` that arrives while `busy` is high is ignored and does not change the transfer in progress.
- R9: `busy` stays high for exactly `80 * (quarter_div + 1)` clock cycles.
- R10: After reset both line enables are 0 (lines released), and `busy`, `done` and `ack_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_div | input | DIV_W | Quarter-bit period minus one, in clock cycles |
| req_start | input | 1 | One-cycle request pulse |
| req_dev | input | 3 | Device number on the bus |
| req_rd | input | 1 | 1 selects a read, 0 a write |
| req_pattern | input | 8 | Output pattern for a write |
| req_inmask | input | 8 | Pins marked as inputs; forced to 1 in the written byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 8 | Byte returned by a read |
| ack_err | output | 1 | An acknowledge slot sampled high |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
A wrong slot or quarter counter shows up at once on the lines. An SDA edge while SCL is high outside start or stop makes a target model count a spurious start or stop, and a shifted slot corrupts the address or data byte that the target decodes within that same byte. A wrong divider or an extra slot changes the measured length of `busy`, which is visible when `done` arrives. A stuck error or sample register shows up as a wrong `ack_err` or `rd_data` in the cycle of `done`.

// File: rtl/i2c_expander_master.sv
module i2c_expander_master #(
  parameter int DIV_W = 12,
  parameter logic [3:0] GROUP = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             req_start,
  input  logic [2:0]       req_dev,
  input  logic             req_rd,
  input  logic [7:0]       req_pattern,
  input  logic [7:0]       req_inmask,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             ack_err,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low
);

  localparam int NSLOT = 18;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);
  localparam logic [SLOT_W-1:0] ACK1_SLOT = SLOT_W'(8);

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_XFER, PH_STOP} phase_t;

  phase_t            phase;
  logic [1:0]        qtr;
  logic [SLOT_W-1:0] slot;
  logic [DIV_W-1:0]  cnt, div_q;
  logic [7:0]        addr_q, data_q, rx_q;
  logic              rd_q, err_q, done_q;

  wire tick      = (cnt == '0);
  wire in_addr   = (slot < SLOT_W'(8));
  wire in_data   = (slot > ACK1_SLOT) && (slot < LAST_SLOT);
  wire ack_slot  = (slot == ACK1_SLOT) || (slot == LAST_SLOT && !rd_q);
  wire [2:0] bidx = in_addr ? ~slot[2:0] : 3'd0 - slot[2:0];

  logic tx_bit;
  always_comb begin
    if (in_addr)               tx_bit = addr_q[bidx];
    else if (in_data && !rd_q) tx_bit = data_q[bidx];
    else                       tx_bit = 1'b1;
  end

  always_comb begin
    unique case (phase)
      PH_START: begin
        scl_drive_low = (qtr == 2'd3);
        sda_drive_low = (qtr != 2'd0);
      end
      PH_XFER: begin
        scl_drive_low = (qtr == 2'd0) || (qtr == 2'd3);
        sda_drive_low = !tx_bit;
      end
      PH_STOP: begin
        scl_drive_low = (qtr == 2'd0);
        sda_drive_low = (qtr < 2'd2);
      end
      default: begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      qtr    <= '0;
      slot   <= '0;
      cnt    <= '0;
      div_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rx_q   <= '0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_start) begin
          phase  <= PH_START;
          qtr    <= '0;
          slot   <= '0;
          cnt    <= quarter_div;
          div_q  <= quarter_div;
          addr_q <= {GROUP, req_dev, req_rd};
          data_q <= req_pattern | req_inmask;
          rd_q   <= req_rd;
          err_q  <= 1'b0;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= div_q;
        qtr <= qtr + 1'b1;
        if (phase == PH_XFER && qtr == 2'd1) begin
          if (ack_slot && sda_in) err_q <= 1'b1;
          if (in_data && rd_q)    rx_q  <= {rx_q[6:0], sda_in};
        end
        if (qtr == 2'd3) begin
          unique case (phase)
            PH_START: begin
              phase <= PH_XFER;
              slot  <= '0;
            end
            PH_XFER: begin
              if (slot == LAST_SLOT) phase <= PH_STOP;
              else                   slot  <= slot + 1'b1;
            end
            default: begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign done    = done_q;
  assign rd_data = rx_q;
  assign ack_err = err_q;

endmodule

// File: rtl/i2c_expander_master_checker.sv
module i2c_expander_master_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_start,
  input logic       busy,
  input logic       done,
  input logic       ack_err,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic [1:0] phase,
  input logic [7:0] addr_q
);
  localparam logic [1:0] CK_START = 2'd1;
  localparam logic [1:0] CK_STOP  = 2'd3;

  p_sda_fall_in_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !$past(scl_drive_low) && $rose(sda_drive_low)) |-> phase == CK_START);

  p_sda_rise_in_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !$past(scl_drive_low) && $fell(sda_drive_low)) |-> phase == CK_STOP);

  p_err_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> busy);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> $stable(addr_q));

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !sda_drive_low));
endmodule

bind i2c_expander_master i2c_expander_master_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .busy(busy), .done(done),
  .ack_err(ack_err), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .phase(phase), .addr_q(addr_q)
);

// File: tb/i2c_expander_master_tb.sv
`timescale 1ns/1ps
module i2c_expander_master_tb;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] quarter_div = '0;
  logic req_start = 1'b0;
  logic [2:0] req_dev = '0;
  logic req_rd = 1'b0;
  logic [7:0] req_pattern = '0, req_inmask = '0;
  logic busy, done, ack_err, scl_drive_low, sda_drive_low;
  logic [7:0] rd_data;

  logic tgt_sda_low = 1'b0;
  wire scl_line = !scl_drive_low;
  wire sda_line = !(sda_drive_low || tgt_sda_low);

  always #10 clk = ~clk;

  i2c_expander_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .req_start(req_start),
    .req_dev(req_dev), .req_rd(req_rd), .req_pattern(req_pattern), .req_inmask(req_inmask),
    .busy(busy), .done(done), .rd_data(rd_data), .ack_err(ack_err), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low));

  // target model of the expander
  logic [2:0] tgt_dev = 3'd5;
  logic ack_addr_en = 1'b1, ack_data_en = 1'b1;
  logic [7:0] port_val = 8'h00;
  int pulse = 0, start_cnt = 0, stop_cnt = 0;
  logic in_txn = 1'b0, sel = 1'b0, nack_seen = 1'b0;
  logic [7:0] addr_rx = '0, wr_rx = '0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_cnt++; in_txn = 1'b1; pulse = 0; sel = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_cnt++; in_txn = 1'b0;
  end
  always @(posedge scl_line) if (in_txn) begin
    pulse++;
    if (pulse <= 8) addr_rx = {addr_rx[6:0], sda_line};
    else if (!addr_rx[0] && pulse >= 10 && pulse <= 17) wr_rx = {wr_rx[6:0], sda_line};
    else if (addr_rx[0] && pulse == 18) nack_seen = sda_line;
  end
  always @(negedge scl_line) if (in_txn) begin
    if (pulse == 8) begin
      sel = (addr_rx[7:1] == {4'b0100, tgt_dev}) && ack_addr_en;
      tgt_sda_low = sel;
    end else if (pulse == 9) tgt_sda_low = sel && addr_rx[0] && !port_val[7];
    else if (pulse >= 10 && pulse <= 16 && addr_rx[0]) tgt_sda_low = sel && !port_val[16-pulse];
    else if (pulse == 17) tgt_sda_low = sel && !addr_rx[0] && ack_data_en;
    else tgt_sda_low = 1'b0;
  end

  int n_checks = 0, n_errs = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  task automatic run_txn(input logic [2:0] dev, input logic rd, input logic [7:0] pat,
                         input logic [7:0] mask, input int div, input int poke_at,
                         output int bcyc);
    int guard;
    @(negedge clk);
    quarter_div = DIV_W'(div); req_dev = dev; req_rd = rd;
    req_pattern = pat; req_inmask = mask; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    bcyc = 0; guard = 0;
    while (!done) begin
      if (busy) bcyc++;
      if (bcyc == poke_at) begin
        req_start = 1'b1; req_dev = 3'd0; req_rd = ~rd; req_pattern = 8'h00;
      end else req_start = 1'b0;
      guard++;
      if (guard > 50000) begin
        check(1'b0, "watchdog transaction", guard, 0);
        finish_run();
      end
      @(negedge clk);
    end
    req_start = 1'b0;
  endtask

  task automatic t_reset();
    check(!busy && !done && !ack_err, "R10 status after reset", {busy, done, ack_err}, 0);
    check(!scl_drive_low && !sda_drive_low, "R10 lines released", {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic t_write();
    int b, s0, p0;
    s0 = start_cnt; p0 = stop_cnt;
    tgt_dev = 3'd5; ack_addr_en = 1'b1; ack_data_en = 1'b1;
    run_txn(3'd5, 1'b0, 8'h3C, 8'h81, 3, -1, b);
    check(addr_rx == 8'h4A, "R1 write address byte", addr_rx, 8'h4A);
    check(wr_rx == 8'hBD, "R3 data is pattern|mask", wr_rx, 8'hBD);
    check(start_cnt - s0 == 1 && stop_cnt - p0 == 1, "R2 R5 one start one stop",
          (start_cnt - s0) * 16 + (stop_cnt - p0), 17);
    check(!ack_err, "R6 no error when acked", ack_err, 0);
    check(b == 320, "R9 busy length div=3", b, 320);
    check(!busy, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
  endtask

  task automatic t_read();
    int b, s0, p0;
    s0 = start_cnt; p0 = stop_cnt;
    tgt_dev = 3'd2; port_val = 8'hA5;
    run_txn(3'd2, 1'b1, 8'h00, 8'h00, 1, -1, b);
    check(addr_rx == 8'h45, "R1 read address byte", addr_rx, 8'h45);
    check(rd_data == 8'hA5, "R4 read data msb first", rd_data, 8'hA5);
    check(nack_seen == 1'b1, "R4 nack after read", nack_seen, 1);
    check(start_cnt - s0 == 1 && stop_cnt - p0 == 1, "R4 R5 start and stop",
          (start_cnt - s0) * 16 + (stop_cnt - p0), 17);
    check(b == 160, "R9 busy length div=1", b, 160);
    port_val = 8'h3C;
    run_txn(3'd2, 1'b1, 8'h00, 8'h00, 0, -1, b);
    check(rd_data == 8'h3C, "R4 second read pattern", rd_data, 8'h3C);
    check(b == 80, "R9 busy length div=0", b, 80);
  endtask

  task automatic t_addr_nack();
    int b, p0;
    p0 = stop_cnt;
    tgt_dev = 3'd5;
    run_txn(3'd3, 1'b0, 8'h55, 8'h00, 2, -1, b);
    check(ack_err, "R6 address nack sets error", ack_err, 1);
    check(stop_cnt - p0 == 1, "R6 stop sent after nack", stop_cnt - p0, 1);
    check(b == 240, "R6 full length after nack", b, 240);
    run_txn(3'd5, 1'b0, 8'h55, 8'h00, 2, -1, b);
    check(!ack_err, "R6 error cleared on new request", ack_err, 0);
  endtask

  task automatic t_data_nack();
    int b, p0;
    p0 = stop_cnt;
    tgt_dev = 3'd6; ack_addr_en = 1'b1; ack_data_en = 1'b0;
    run_txn(3'd6, 1'b0, 8'h0F, 8'hF0, 1, -1, b);
    check(ack_err, "R6 data nack sets error", ack_err, 1);
    check(stop_cnt - p0 == 1, "R6 stop after data nack", stop_cnt - p0, 1);
    ack_data_en = 1'b1;
  endtask

  task automatic t_ignore_start();
    int b, s0;
    s0 = start_cnt;
    tgt_dev = 3'd5;
    run_txn(3'd5, 1'b0, 8'h11, 8'h00, 1, 40, b);
    check(addr_rx == 8'h4A, "R8 address kept despite start", addr_rx, 8'h4A);
    check(wr_rx == 8'h11, "R8 data kept despite start", wr_rx, 8'h11);
    check(b == 160, "R8 length unchanged", b, 160);
    repeat (50) @(negedge clk);
    check(!busy && start_cnt - s0 == 1, "R8 no second transfer", start_cnt - s0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_addr_nack();
    t_data_nack();
    t_ignore_start();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog global", 0, 1);
    finish_run();
  end
endmodule